// File: doc/BRIEF.md
# Sample Packer with Burst Memory Writer

The block moves a requested number of 32-bit samples from a show-ahead FIFO into external memory through an Avalon-MM write master. A command gives a sample count and a byte start address. The block gathers eight samples into each 256-bit write beat, with the first sample in the lowest lane. It issues fixed-length bursts whose length `BURST_LEN` is chosen at elaboration.

The sample count need not be a multiple of the samples carried by one burst. The block rounds the transfer up to whole bursts and fills every lane after the last real sample with zero, so the memory side always sees complete bursts. When the final beat is accepted, a one-cycle done pulse is raised. The FIFO, the master port and the command port all share the memory controller's user clock and its synchronous active-high reset.

A beat is offered only after all of its lanes are gathered. If the FIFO runs dry in the middle of a beat, the block waits. While it is padding, it does not read the FIFO at all.

Top module: `spk_burst_writer`

## Requirements
- R1: Within a beat, sample k of that beat (k = 0..7) occupies `av_writedata[32k+31:32k]`. The first FIFO sample of a transfer lands in lane 0 of the first beat.
- R2: A transfer of N samples produces ceil(N / (8·BURST_LEN)) bursts of exactly BURST_LEN beats each, and `av_burstcount` equals BURST_LEN on every beat.
- R3: Burst j of a transfer is presented at byte address start + j·BURST_LEN·32.
- R4: Lanes at sample positions N and above are written as zero. The FIFO is popped exactly N times per transfer, even when it holds more data.
- R5: While `av_write` is high and `av_waitrequest` is high, the block keeps `av_write`, `av_address`, `av_burstcount` and `av_writedata` unchanged on the next cycle.
- R6: `av_byteenable` is all ones on every beat, padding beats included.
- R7: `fifo_rd` is asserted only while `fifo_empty` is low. The FIFO is show-ahead: `fifo_data` is valid whenever `fifo_empty` is low, and a high `fifo_rd` pops it at the clock edge. Gaps in FIFO data do not disturb lane order.
- R8: `cmd_done` is high for exactly one cycle, in the cycle after the edge that accepts the last beat. For N = 0, it is high in the cycle after the start is taken, and no beat is written.
- R9: A `cmd_start` pulse that arrives while a transfer is in progress has no effect on that transfer's data, addresses or beat count.
- R10: While `rst` is high, and in the cycle after it, `av_write`, `cmd_done` and `fifo_rd` are low. Reset aborts a transfer, and the next transfer starts in lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller user clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse; ignored while busy |
| cmd_count | input | CNT_W | Number of samples to move |
| cmd_addr | input | ADDR_W | Byte address of the first burst |
| cmd_done | output | 1 | One-cycle completion pulse |
| fifo_data | input | LANE_W | Head sample of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no sample |
| fifo_rd | output | 1 | Pop the head sample |
| av_address | output | ADDR_W | Burst byte address |
| av_write | output | 1 | Write request |
| av_writedata | output | LANE_W·LANES | Packed beat |
| av_burstcount | output | log2(BURST_LEN)+1 | Beats per burst |
| av_byteenable | output | LANE_W·LANES/8 | Byte enables, all ones |
| av_waitrequest | input | 1 | Slave stall |

## Verification
On every cycle, the embedded properties check three things: that a stalled beat keeps its write, address and data; that no lane is written while a gathered beat waits; and that the done flag is a single pulse that follows an accepted beat or a start. They also check the address step at each burst boundary and the quiet state after reset. Only the bench's scenarios can show the content of each beat, the zero padding, the exact number of FIFO pops, the burst count for arbitrary N, and the fact that a start arriving mid-transfer changes nothing. The bench does this by sweeping sample counts around the beat and burst boundaries against several stall and FIFO-gap patterns.

// File: rtl/spk_pkg.sv
package spk_pkg;

   typedef enum logic {
      SPK_IDLE = 1'b0,
      SPK_RUN  = 1'b1
   } spk_state_e;

   function automatic bit spk_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/spk_lane_packer.sv
module spk_lane_packer #(
   parameter int LANE_W = 32,
   parameter int LANES  = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      clr,
   input  logic                      lane_we,
   input  logic [LANE_W-1:0]         lane_val,
   output logic [LANE_W*LANES-1:0]   beat,
   output logic                      beat_full
);

   localparam int LI_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [LI_W-1:0] LAST_LANE = LI_W'(LANES - 1);

   logic [LI_W-1:0] idx_q;
   logic            full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (clr)
            full_q <= 1'b0;
         if (lane_we) begin
            if (idx_q == LAST_LANE) begin
               idx_q  <= '0;
               full_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign beat_full = full_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (lane_we && (idx_q == LI_W'(i)))
            q <= lane_val;
      end
      assign beat[i*LANE_W +: LANE_W] = q;
   end

   // R1: a gathered beat must not be overwritten before it is taken
   p_no_fill_when_full_r1: assert property (@(posedge clk) disable iff (rst)
      lane_we |-> !full_q);

endmodule

// File: rtl/spk_burst_seq.sv
module spk_burst_seq
   import spk_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 32,
   parameter int BURST_LEN  = 4,
   parameter int LANES      = 8,
   parameter int BEAT_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_start,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              fifo_empty,
   input  logic              beat_full,
   input  logic              av_waitrequest,
   output logic              fifo_rd,
   output logic              lane_we,
   output logic              pad_sel,
   output logic              av_write,
   output logic              beat_clr,
   output logic [ADDR_W-1:0] av_address,
   output logic              done
);

   localparam int SPB     = LANES * BURST_LEN;
   localparam int SPB_LOG = $clog2(SPB);
   localparam int BI_W    = $clog2(BURST_LEN);
   localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(BURST_LEN * BEAT_BYTES);
   localparam logic [BI_W-1:0]   LAST_BEAT  = BI_W'(BURST_LEN - 1);

   spk_state_e        state_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  bursts_q;
   logic [BI_W-1:0]   bidx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;

   logic [CNT_W:0]    ceil_sum;
   logic [CNT_W-1:0]  bursts_calc;
   logic              running;
   logic              fill_ok;
   logic              have_real;
   logic              accept;
   logic              last_beat;

   assign ceil_sum    = {1'b0, cmd_count} + (CNT_W+1)'(SPB - 1);
   assign bursts_calc = CNT_W'(ceil_sum >> SPB_LOG);

   assign running   = (state_q == SPK_RUN);
   assign fill_ok   = running && !beat_full;
   assign have_real = (rem_q != '0);
   assign fifo_rd   = fill_ok && have_real && !fifo_empty;
   assign lane_we   = fill_ok && (!have_real || !fifo_empty);
   assign pad_sel   = !have_real;
   assign av_write  = running && beat_full;
   assign accept    = av_write && !av_waitrequest;
   assign beat_clr  = accept;
   assign last_beat = (bidx_q == LAST_BEAT);
   assign av_address = addr_q;
   assign done       = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= SPK_IDLE;
         rem_q    <= '0;
         bursts_q <= '0;
         bidx_q   <= '0;
         addr_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SPK_IDLE: begin
               if (cmd_start) begin
                  rem_q    <= cmd_count;
                  bursts_q <= bursts_calc;
                  addr_q   <= cmd_addr;
                  bidx_q   <= '0;
                  if (bursts_calc == '0)
                     done_q <= 1'b1;
                  else
                     state_q <= SPK_RUN;
               end
            end
            SPK_RUN: begin
               if (fifo_rd)
                  rem_q <= rem_q - 1'b1;
               if (accept) begin
                  if (last_beat) begin
                     bidx_q   <= '0;
                     addr_q   <= addr_q + BURST_STEP;
                     bursts_q <= bursts_q - 1'b1;
                     if (bursts_q == CNT_W'(1)) begin
                        state_q <= SPK_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     bidx_q <= bidx_q + 1'b1;
                  end
               end
            end
            default: state_q <= SPK_IDLE;
         endcase
      end
   end

   // R8: completion is a single-cycle pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: completion follows either an accepted beat or a start
   p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(accept || cmd_start));

   // R3: the address moves by one burst after a burst ends mid-transfer
   p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
      (accept && last_beat && (bursts_q > CNT_W'(1))) |=>
         (av_address == $past(av_address) + BURST_STEP));

endmodule

// File: rtl/spk_burst_writer.sv
module spk_burst_writer
   import spk_pkg::*;
#(
   parameter int LANE_W    = 32,
   parameter int LANES     = 8,
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 32,
   localparam int DATA_W   = LANE_W * LANES,
   localparam int BE_W     = DATA_W / 8,
   localparam int BC_W     = $clog2(BURST_LEN) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_start,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_done,
   input  logic [LANE_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_rd,
   output logic [ADDR_W-1:0] av_address,
   output logic              av_write,
   output logic [DATA_W-1:0] av_writedata,
   output logic [BC_W-1:0]   av_burstcount,
   output logic [BE_W-1:0]   av_byteenable,
   input  logic              av_waitrequest
);

   localparam int BEAT_BYTES = DATA_W / 8;

   if (!spk_is_pow2(BURST_LEN) || BURST_LEN < 4 || BURST_LEN > 1024) begin : g_bad_burst
      $error("spk_burst_writer: BURST_LEN must be a power of two in 4..1024");
   end
   if (!spk_is_pow2(LANES) || LANES < 2) begin : g_bad_lanes
      $error("spk_burst_writer: LANES must be a power of two of at least 2");
   end
   if ((LANE_W % 8) != 0) begin : g_bad_lane_w
      $error("spk_burst_writer: LANE_W must be a whole number of bytes");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spk_burst_writer: CNT_W too small");
   end

   logic              lane_we;
   logic              pad_sel;
   logic              beat_clr;
   logic              beat_full;
   logic [LANE_W-1:0] lane_val;

   assign lane_val      = pad_sel ? '0 : fifo_data;
   assign av_burstcount = BC_W'(BURST_LEN);
   assign av_byteenable = '1;

   spk_burst_seq #(
      .CNT_W      (CNT_W),
      .ADDR_W     (ADDR_W),
      .BURST_LEN  (BURST_LEN),
      .LANES      (LANES),
      .BEAT_BYTES (BEAT_BYTES)
   ) seq_i (
      .clk            (clk),
      .rst            (rst),
      .cmd_start      (cmd_start),
      .cmd_count      (cmd_count),
      .cmd_addr       (cmd_addr),
      .fifo_empty     (fifo_empty),
      .beat_full      (beat_full),
      .av_waitrequest (av_waitrequest),
      .fifo_rd        (fifo_rd),
      .lane_we        (lane_we),
      .pad_sel        (pad_sel),
      .av_write       (av_write),
      .beat_clr       (beat_clr),
      .av_address     (av_address),
      .done           (cmd_done)
   );

   spk_lane_packer #(
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) pack_i (
      .clk       (clk),
      .rst       (rst),
      .clr       (beat_clr),
      .lane_we   (lane_we),
      .lane_val  (lane_val),
      .beat      (av_writedata),
      .beat_full (beat_full)
   );

   // R5: a stalled beat keeps its request, address and data
   p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (rst)
      (av_write && av_waitrequest) |=>
         (av_write && $stable(av_writedata) && $stable(av_address)));

   // R10: reset leaves the outputs quiet
   p_quiet_after_reset_r10: assert property (@(posedge clk)
      rst |=> (!av_write && !cmd_done && !fifo_rd));

endmodule

// File: tb/spk_burst_writer_tb_top.sv
module spk_burst_writer_tb_top;

   localparam int LANE_W    = 32;
   localparam int LANES     = 8;
   localparam int BURST_LEN = 4;
   localparam int CNT_W     = 16;
   localparam int ADDR_W    = 32;
   localparam int DATA_W    = LANE_W * LANES;
   localparam int BE_W      = DATA_W / 8;
   localparam int BC_W      = $clog2(BURST_LEN) + 1;
   localparam int SPB       = LANES * BURST_LEN;
   localparam int STEP      = BURST_LEN * DATA_W / 8;

   logic              clk = 1'b0;
   logic              rst;
   logic              cmd_start;
   logic [CNT_W-1:0]  cmd_count;
   logic [ADDR_W-1:0] cmd_addr;
   logic              cmd_done;
   logic [LANE_W-1:0] fifo_data;
   logic              fifo_empty;
   logic              fifo_rd;
   logic [ADDR_W-1:0] av_address;
   logic              av_write;
   logic [DATA_W-1:0] av_writedata;
   logic [BC_W-1:0]   av_burstcount;
   logic [BE_W-1:0]   av_byteenable;
   logic              av_waitrequest;

   always #5 clk = ~clk;

   spk_burst_writer #(
      .LANE_W(LANE_W), .LANES(LANES), .BURST_LEN(BURST_LEN),
      .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) dut_i (
      .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_count(cmd_count),
      .cmd_addr(cmd_addr), .cmd_done(cmd_done), .fifo_data(fifo_data),
      .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .av_address(av_address),
      .av_write(av_write), .av_writedata(av_writedata),
      .av_burstcount(av_burstcount), .av_byteenable(av_byteenable),
      .av_waitrequest(av_waitrequest)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int tag    = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [LANE_W-1:0] smp(input int t, input int k);
      return 32'hA000_0000 ^ (32'(t) << 16) ^ 32'(k + 1);
   endfunction

   function automatic bit wait_on(input int mode, input int c);
      case (mode)
         1:       return (c % 3) == 0;
         2:       return (c % 7) < 4;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit empty_on(input int mode, input int c);
      case (mode)
         1:       return (c % 2) == 1;
         2:       return (c % 5) < 3;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run_xfer(input int n, input logic [ADDR_W-1:0] addr,
                           input int wm, input int em, input bit poke);
      int exp_bursts = (n + SPB - 1) / SPB;
      int exp_beats  = exp_bursts * BURST_LEN;
      int beats = 0;
      int pops  = 0;
      bit expect_done = 1'b0;
      bit finished = 1'b0;
      bit hold_v = 1'b0;
      logic [ADDR_W-1:0] h_addr;
      logic [DATA_W-1:0] h_data;
      logic [BC_W-1:0]   h_bc;
      logic [DATA_W-1:0] exp_beat;
      tag++;
      @(negedge clk);
      cmd_start = 1'b1;
      cmd_count = CNT_W'(n);
      cmd_addr  = addr;
      for (int cyc = 0; cyc < 20000; cyc++) begin
         if (cyc > 0) begin
            // R9: a second start mid-transfer with other parameters
            cmd_start = poke && (cyc == 10);
            if (poke && cyc == 10) begin
               cmd_count = CNT_W'(5);
               cmd_addr  = 32'hFFFF_0000;
            end
         end
         if (cyc == 1 && exp_beats == 0) expect_done = 1'b1;
         av_waitrequest = wait_on(wm, cyc);
         fifo_empty     = empty_on(em, cyc);
         fifo_data      = fifo_empty ? 32'hDEAD_BEEF : smp(tag, pops);
         #1;
         if (expect_done) begin
            chk(cmd_done, "R8", "done after last beat", DATA_W'(cmd_done), 1);
            finished = 1'b1;
            break;
         end else if (cmd_done) begin
            chk(1'b0, "R8", "early done", DATA_W'(beats), DATA_W'(exp_beats));
         end
         if (hold_v) begin
            chk(av_write && av_address == h_addr && av_writedata == h_data &&
                av_burstcount == h_bc, "R5", "stalled beat changed",
                av_writedata, h_data);
            hold_v = 1'b0;
         end
         if (av_write && av_waitrequest) begin
            hold_v = 1'b1;
            h_addr = av_address;
            h_data = av_writedata;
            h_bc   = av_burstcount;
         end
         if (fifo_rd) begin
            chk(!fifo_empty, "R7", "pop while empty", DATA_W'(fifo_empty), 0);
            pops++;
         end
         if (av_write && !av_waitrequest) begin
            for (int l = 0; l < LANES; l++) begin
               int s = beats * LANES + l;
               exp_beat[l*LANE_W +: LANE_W] = (s < n) ? smp(tag, s) : '0;
            end
            chk(av_writedata == exp_beat, "R1 R4", "beat data", av_writedata, exp_beat);
            chk(av_byteenable == '1, "R6", "byteenable", DATA_W'(av_byteenable), DATA_W'({BE_W{1'b1}}));
            if (beats % BURST_LEN == 0) begin
               chk(av_address == addr + ADDR_W'((beats / BURST_LEN) * STEP), "R3",
                   "burst address", DATA_W'(av_address),
                   DATA_W'(addr + ADDR_W'((beats / BURST_LEN) * STEP)));
               chk(av_burstcount == BC_W'(BURST_LEN), "R2", "burstcount",
                   DATA_W'(av_burstcount), DATA_W'(BURST_LEN));
            end
            beats++;
            if (beats == exp_beats) expect_done = 1'b1;
         end
         @(negedge clk);
      end
      cmd_start = 1'b0;
      chk(finished, "R8", "transfer timed out", DATA_W'(beats), DATA_W'(exp_beats));
      chk(beats == exp_beats, "R2", "beat count", DATA_W'(beats), DATA_W'(exp_beats));
      chk(pops == n, "R4", "FIFO pop count", DATA_W'(pops), DATA_W'(n));
      @(negedge clk);
      av_waitrequest = 1'b0;
      fifo_empty = 1'b0;
      #1;
      chk(!cmd_done && !av_write, "R8", "done not single cycle or write after end",
          DATA_W'({cmd_done, av_write}), 0);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int ns[11] = '{0, 1, 7, 8, 9, 31, 32, 33, 64, 100, 200};
      rst = 1'b1;
      cmd_start = 1'b0;
      cmd_count = '0;
      cmd_addr = '0;
      fifo_data = 32'h1234_5678;
      fifo_empty = 1'b0;
      av_waitrequest = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!av_write && !cmd_done && !fifo_rd, "R10", "outputs in reset",
          DATA_W'({av_write, cmd_done, fifo_rd}), 0);
      rst = 1'b0;

      for (int i = 0; i < 11; i++)
         for (int wm = 0; wm < 3; wm++)
            for (int em = 0; em < 3; em++)
               run_xfer(ns[i], 32'h1000_0000 + ADDR_W'(tag) * 32'h1_0000, wm, em,
                        (ns[i] >= 33) && (wm == 1));

      // R10: reset in the middle of a transfer
      @(negedge clk);
      cmd_start = 1'b1;
      cmd_count = CNT_W'(100);
      cmd_addr = 32'h2000_0000;
      fifo_data = 32'h5555_AAAA;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (13) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1;
      chk(!av_write && !cmd_done && !fifo_rd, "R10", "outputs after mid reset",
          DATA_W'({av_write, cmd_done, fifo_rd}), 0);
      rst = 1'b0;
      run_xfer(40, 32'h3000_0000, 0, 1, 1'b0);
      run_xfer(100, 32'h3100_0000, 2, 2, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule